// File: doc/BRIEF.md
# Host Mailbox Interrupt Latch Controller

This block handles the interrupt side of a four-channel mailbox between a host and a slave processor. On the slave side it raises one level interrupt per channel. That interrupt is high while the channel's inbound data register holds unread data and the channel's enable is set. The data registers, the status registers and the host bus decoding sit outside the block. They supply the full flags, the enables and the raw host read signals.

On the host side the block keeps five request latches, each driving one host interrupt pin. Slave firmware raises a request by writing a 1 into a latch. The host's service routine drops the request by reading the outbound register of the channel that owns the latch. The link between channels and latches is fixed and uneven:

- A read on channel 1 drops two latches.
- The latch that belongs to the channel-2 read sits beside the channel-1 pair.

A per-pin direction bit decides whether a latch actually drives its pin. The asynchronous host read strobe is brought into the slave clock domain through a synchronizer. The latch is cleared on the strobe's falling edge.

Top module: `hif_irq_ctrl`

## Requirements
- R1: `slv_irq[i]` is high one clock after a rising edge on which `ibf_full[i]` and `ibf_en[i]` were both 1, and low one clock after an edge on which either was 0.
- R2: After reset, `slv_irq` and `host_irq` are all 0, every request latch is 0 and every direction bit is 0.
- R3: A firmware write (`fw_req_we`=1) sets each latch whose bit in `fw_req_data` is 1. Latches whose bit is 0 keep their value.
- R4: `host_irq[j]` equals latch j when direction bit j is 1, and is 0 otherwise. A write with `fw_dir_we`=1 loads all five direction bits from `fw_dir_data`.
- R5: A host read on channel 1 (`host_cs_n[0]`=0) clears latch bits 0 and 1.
- R6: A host read on channel 2 (`host_cs_n[1]`=0) clears latch bit 2 only.
- R7: A host read on channel 3 clears latch bit 3, and a read on channel 4 clears latch bit 4.
- R8: A clear takes place only when the synchronized `host_a0` is 0 at the strobe's falling edge. A read with `host_a0`=1 changes no latch.
- R9: `host_rd_n` passes through two synchronizer flops. A clear takes effect on the third rising edge that counts from the first edge sampling `host_rd_n` low. Holding the strobe low clears nothing further.
- R10: If a firmware set and a host clear reach the same latch in the same cycle, the latch ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_n | input | 4 | Active-low channel selects, bit i is channel i+1 |
| host_a0 | input | 1 | Host address bit 0 |
| host_rd_n | input | 1 | Asynchronous active-low host read strobe |
| ibf_full | input | 4 | Inbound data register full flags, one per channel |
| ibf_en | input | 4 | Slave interrupt enables, one per channel |
| fw_req_we | input | 1 | Firmware write strobe for the request latches |
| fw_req_data | input | 5 | Firmware set pattern, 1 sets a latch |
| fw_dir_we | input | 1 | Firmware write strobe for the direction bits |
| fw_dir_data | input | 5 | Direction bits to load, 1 enables the pin |
| slv_irq | output | 4 | Registered active-high slave interrupts |
| host_irq | output | 5 | Host interrupt request pins |

## Verification
The assertions assume that the select lines and `host_a0` are stable whenever the read strobe falls. They are synchronized with the same depth as the strobe, so the decoded channel lines up with the detected edge. The bench keeps to that assumption. Every host read drives the selects, the address bit and the strobe together on a falling clock edge and holds them for several cycles before releasing them all. The only deliberate overlap is a firmware set timed into the exact cycle where the clear lands.

// File: rtl/hif_irq_pkg.sv
package hif_irq_pkg;
  localparam int NUM_CH  = 4;
  localparam int NUM_REQ = 5;
  localparam int CH_W    = $clog2(NUM_CH);

  typedef logic [NUM_REQ-1:0] req_vec_t;
  typedef logic [NUM_CH-1:0]  ch_vec_t;

  // Which request latches a host read on channel ch drops.
  function automatic req_vec_t clr_map(input int ch);
    req_vec_t m;
    m = '0;
    case (ch)
      0: m = 5'b00011;
      1: m = 5'b00100;
      2: m = 5'b01000;
      3: m = 5'b10000;
      default: m = '0;
    endcase
    return m;
  endfunction

  // Slave interrupt condition for a channel group.
  function automatic ch_vec_t ibf_request(input ch_vec_t full, input ch_vec_t en);
    return full & en;
  endfunction

  // Next latch state: sets merge in, clears override.
  function automatic req_vec_t latch_next(input req_vec_t cur, input req_vec_t set,
                                          input req_vec_t clr);
    return (cur | set) & ~clr;
  endfunction
endpackage

// File: rtl/hif_rd_sync.sv
module hif_rd_sync #(
  parameter int STAGES = 2,
  parameter int NCH    = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] cs_n_in,
  input  logic           a0_in,
  input  logic           rd_n_in,
  output logic [NCH-1:0] cs_n_s,
  output logic           a0_s,
  output logic           rd_fall
);
  localparam int W = NCH + 2;

  logic [STAGES-1:0][W-1:0] pipe;
  logic                     rd_prev;
  logic [W-1:0]             last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= {{NCH{1'b1}}, 1'b0, 1'b1};
    end else begin
      pipe[0] <= {cs_n_in, a0_in, rd_n_in};
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign last = pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_prev <= 1'b1;
    else        rd_prev <= last[0];
  end

  assign cs_n_s  = last[W-1:2];
  assign a0_s    = last[1];
  assign rd_fall = rd_prev & ~last[0];
endmodule

// File: rtl/hif_clr_decode.sv
module hif_clr_decode
  import hif_irq_pkg::*;
(
  input  logic     rd_fall,
  input  logic     a0_s,
  input  ch_vec_t  cs_n_s,
  output req_vec_t clr_vec
);
  req_vec_t ch_clr [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ch_clr[c] = (rd_fall && !a0_s && !cs_n_s[c]) ? clr_map(c) : '0;
  end

  always_comb begin
    clr_vec = '0;
    for (int c = 0; c < NUM_CH; c++) clr_vec = clr_vec | ch_clr[c];
  end
endmodule

// File: rtl/hif_req_latch.sv
module hif_req_latch
  import hif_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  req_vec_t set_vec,
  input  req_vec_t clr_vec,
  input  logic     dir_we,
  input  req_vec_t dir_data,
  output req_vec_t latch_q,
  output req_vec_t dir_q,
  output req_vec_t pin
);
  for (genvar j = 0; j < NUM_REQ; j++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        latch_q[j] <= 1'b0;
        dir_q[j]   <= 1'b0;
      end else begin
        latch_q[j] <= (latch_q[j] | set_vec[j]) & ~clr_vec[j];
        if (dir_we) dir_q[j] <= dir_data[j];
      end
    end
    assign pin[j] = latch_q[j] & dir_q[j];
  end
endmodule

// File: rtl/hif_ibf_irq.sv
module hif_ibf_irq
  import hif_irq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  ch_vec_t full,
  input  ch_vec_t en,
  output ch_vec_t irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= '0;
    else        irq <= ibf_request(full, en);
  end
endmodule

// File: rtl/hif_irq_ctrl.sv
module hif_irq_ctrl
  import hif_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   host_cs_n,
  input  logic         host_a0,
  input  logic         host_rd_n,
  input  logic [3:0]   ibf_full,
  input  logic [3:0]   ibf_en,
  input  logic         fw_req_we,
  input  logic [4:0]   fw_req_data,
  input  logic         fw_dir_we,
  input  logic [4:0]   fw_dir_data,
  output logic [3:0]   slv_irq,
  output logic [4:0]   host_irq
);
  // Named internal events, observed by the bound checker.
  ch_vec_t  cs_n_s;
  logic     a0_s;
  logic     rd_fall;
  req_vec_t clr_vec;
  req_vec_t set_vec;
  req_vec_t latch_q;
  req_vec_t dir_q;

  assign set_vec = fw_req_we ? fw_req_data : '0;

  hif_rd_sync #(.STAGES(SYNC_STAGES), .NCH(NUM_CH)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .cs_n_in(host_cs_n), .a0_in(host_a0), .rd_n_in(host_rd_n),
    .cs_n_s(cs_n_s), .a0_s(a0_s), .rd_fall(rd_fall)
  );

  hif_clr_decode u_dec (
    .rd_fall(rd_fall), .a0_s(a0_s), .cs_n_s(cs_n_s), .clr_vec(clr_vec)
  );

  hif_req_latch u_latch (
    .clk(clk), .rst_n(rst_n),
    .set_vec(set_vec), .clr_vec(clr_vec),
    .dir_we(fw_dir_we), .dir_data(fw_dir_data),
    .latch_q(latch_q), .dir_q(dir_q), .pin(host_irq)
  );

  hif_ibf_irq u_ibf (
    .clk(clk), .rst_n(rst_n), .full(ibf_full), .en(ibf_en), .irq(slv_irq)
  );
endmodule

// File: rtl/hif_irq_chk.sv
module hif_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] ibf_full,
  input logic [3:0] ibf_en,
  input logic [3:0] slv_irq,
  input logic [4:0] host_irq,
  input logic       a0_s,
  input logic       rd_fall,
  input logic [4:0] clr_vec,
  input logic [4:0] set_vec,
  input logic [4:0] latch_q,
  input logic [4:0] dir_q
);
  p_slv_irq_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> slv_irq == $past(ibf_full & ibf_en));

  p_pin_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_irq & ~dir_q) == 5'b0);

  p_set_takes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (latch_q & $past(set_vec & ~clr_vec)) == $past(set_vec & ~clr_vec));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((latch_q ^ $past(latch_q)) & ~$past(set_vec | clr_vec)) == 5'b0);

  p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (latch_q & $past(clr_vec)) == 5'b0);

  p_clr_needs_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != 5'b0) |-> rd_fall);

  p_single_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fall |=> !rd_fall);

  p_a0_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    a0_s |-> clr_vec == 5'b0);
endmodule

bind hif_irq_ctrl hif_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ibf_full(ibf_full), .ibf_en(ibf_en),
  .slv_irq(slv_irq), .host_irq(host_irq), .a0_s(a0_s), .rd_fall(rd_fall),
  .clr_vec(clr_vec), .set_vec(set_vec), .latch_q(latch_q), .dir_q(dir_q)
);

// File: tb/tb_hif_irq_ctrl.sv
`timescale 1ns/1ps
module tb_hif_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] host_cs_n = 4'hF;
  logic       host_a0 = 1'b0;
  logic       host_rd_n = 1'b1;
  logic [3:0] ibf_full = '0;
  logic [3:0] ibf_en = '0;
  logic       fw_req_we = 1'b0;
  logic [4:0] fw_req_data = '0;
  logic       fw_dir_we = 1'b0;
  logic [4:0] fw_dir_data = '0;
  logic [3:0] slv_irq;
  logic [4:0] host_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hif_irq_ctrl dut (.*);

  // {full, en, expected slv_irq}
  localparam logic [11:0] VEC [8] = '{
    12'h0_F_0, 12'hF_0_0, 12'hF_F_F, 12'h5_F_5,
    12'hF_A_A, 12'h3_6_2, 12'h8_8_8, 12'h1_E_0
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fw_set(input logic [4:0] m);
    @(negedge clk); fw_req_we = 1'b1; fw_req_data = m;
    @(negedge clk); fw_req_we = 1'b0; fw_req_data = '0;
  endtask

  task automatic fw_dir(input logic [4:0] m);
    @(negedge clk); fw_dir_we = 1'b1; fw_dir_data = m;
    @(negedge clk); fw_dir_we = 1'b0;
  endtask

  task automatic host_read(input int ch, input logic a0);
    @(negedge clk); host_cs_n = ~(4'b1 << ch); host_a0 = a0; host_rd_n = 1'b0;
    repeat (4) @(negedge clk);
    host_rd_n = 1'b1; host_cs_n = 4'hF; host_a0 = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 slv_irq", {4'b0, slv_irq}, 8'h00);
    check("R2 host_irq", {3'b0, host_irq}, 8'h00);
    fw_dir(5'b11111);
    check("R2 latches clear", {3'b0, host_irq}, 8'h00);
    fw_dir(5'b00000);

    for (int i = 0; i < 8; i++) begin
      @(negedge clk); ibf_full = VEC[i][11:8]; ibf_en = VEC[i][7:4];
      @(negedge clk);
      check($sformatf("R1 vec%0d", i), {4'b0, slv_irq}, {4'b0, VEC[i][3:0]});
    end
    ibf_full = '0; ibf_en = '0;

    fw_set(5'b11111);
    @(negedge clk);
    check("R4 dir off", {3'b0, host_irq}, 8'h00);
    fw_dir(5'b10101);
    check("R4 dir partial", {3'b0, host_irq}, 8'h15);
    fw_dir(5'b11111);
    check("R4 dir all", {3'b0, host_irq}, 8'h1F);
    fw_set(5'b00000);
    check("R3 zero write", {3'b0, host_irq}, 8'h1F);

    host_read(0, 1'b0);
    check("R5 ch1 read", {3'b0, host_irq}, 8'h1C);
    host_read(1, 1'b1);
    check("R8 a0 high", {3'b0, host_irq}, 8'h1C);
    host_read(1, 1'b0);
    check("R6 ch2 read", {3'b0, host_irq}, 8'h18);
    host_read(2, 1'b0);
    check("R7 ch3 read", {3'b0, host_irq}, 8'h10);
    host_read(3, 1'b0);
    check("R7 ch4 read", {3'b0, host_irq}, 8'h00);
    fw_set(5'b00100);
    check("R3 single set", {3'b0, host_irq}, 8'h04);

    // R9 timing: read ch2 with latch bit 2 set.
    @(negedge clk); host_cs_n = 4'b1101; host_rd_n = 1'b0;
    @(negedge clk);
    check("R9 after 1 edge", {3'b0, host_irq}, 8'h04);
    @(negedge clk);
    check("R9 after 2 edges", {3'b0, host_irq}, 8'h04);
    @(negedge clk);
    check("R9 after 3 edges", {3'b0, host_irq}, 8'h00);
    fw_set(5'b00100);
    repeat (3) @(negedge clk);
    check("R9 held low", {3'b0, host_irq}, 8'h04);
    host_rd_n = 1'b1; host_cs_n = 4'hF;
    repeat (4) @(negedge clk);

    // R10: set lands in the same cycle as the clear of bit 4.
    host_cs_n = 4'b0111; host_rd_n = 1'b0;
    @(negedge clk);
    @(negedge clk); fw_req_we = 1'b1; fw_req_data = 5'b10000;
    @(negedge clk); fw_req_we = 1'b0; fw_req_data = '0;
    check("R10 clear wins", {3'b0, host_irq}, 8'h04);
    host_rd_n = 1'b1; host_cs_n = 4'hF;
    repeat (4) @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule